// File: doc/BRIEF.md
# PWM Soft-Start Edge Ramp Modulator

This block drives four pulse-width outputs from one shared switching-period counter. Each output has a programmed rising-edge tick and falling-edge tick. While soft start is enabled, one edge of each output stays fixed and the other, modulated, edge begins displaced earlier by a soft-start span. Each switching period it moves later by a programmable step, until it lands on its programmed tick. Outputs 1 and 2 move their falling edge. Outputs 3 and 4 move their rising edge.

Two spans are derived from the edge registers: span A serves outputs 1 and 3, and span B serves outputs 2 and 4. A configuration byte selects other edge differences for the spans and can enable an ordering guard. While the ramp is in progress, the guard blanks any output whose edges would appear in the forbidden order. A done flag reports that both offsets have reached zero. All edge times are tick counts of the period counter.

Top module: `ssr_pwm_softstart`

## Requirements
- R1: Counter `c` runs 0..period-1. With rising position r and falling position f, an output is high when r <= c < f if r < f, when c >= r or c < f if r > f, and low for the whole period when r == f. `pwm_o` shows the value for counter value c in the cycle after c is counted, and the counter is 0 in the first cycle after reset.
- R2: Outputs 1 and 2 (bits 0 and 1) place their falling edge at (fall - offset) mod period and keep the rising edge at its programmed tick. Outputs 3 and 4 (bits 2 and 3) place their rising edge at (rise - offset) mod period and keep the falling edge fixed. Outputs 1 and 3 use offset A. Outputs 2 and 4 use offset B.
- R3: With configuration bits 3..0 all clear, span A = (fall1 - rise1) mod period and span B = (fall2 - rise2) mod period. Outputs 1 and 2 therefore start at zero duty.
- R4: Config bit 1 sets span A = |fall3 - rise3|. Config bit 2 sets span B = period - rise2. Config bit 0 sets span B = |fall4 - rise4|, and bit 0 wins over bit 2.
- R5: Config bit 3 replaces span A with the final span B.
- R6: A progress count starts at 0. At each period end while enabled it grows by `step_i`, saturating at the period. Offset = span - progress, floored at 0. Offsets change only at a period end.
- R7: `ramp_done_o` is updated only at a period end. It is set there when enable is high and both offsets are zero, and otherwise cleared.
- R8: A period end seen with enable low clears progress, so the next period uses the full spans.
- R9: With config bit 7 set and the ramp not done, an output 1 or 2 whose falling position is below its rising position has its falling edge moved onto the rising edge, which makes it low.
- R10: With bit 7 set and the ramp not done, outputs 3 and 4 are handled as follows. If bit 6 is 0, a rising position below the falling position is moved onto the falling edge. If bit 6 is 1, a falling position below the rising position moves the rising edge onto the falling edge.
- R11: With bit 7 clear, or once the ramp is done, no output is altered by the ordering guard.
- R12: During reset `pwm_o` is 0 and `ramp_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CW | Switching period in ticks (at least 2) |
| rise_i | input | 4*CW | Programmed rising-edge ticks, one per output |
| fall_i | input | 4*CW | Programmed falling-edge ticks, one per output |
| ss_en_i | input | 1 | Soft-start ramp enable |
| step_i | input | CW | Progress added per period |
| cfg_i | input | 8 | Span selection (bits 3..0) and ordering guard (bits 7..6) |
| pwm_o | output | 4 | PWM outputs |
| ramp_done_o | output | 1 | Both offsets have reached zero |

## Verification
The ordering guard and the ramp completion can meet at the same period end. In that period the guard must be released exactly when both offsets hit zero, so a blanked output turns on at its programmed duty in the very next period. The bench provokes this by running guarded configurations through to completion. It counts high cycles over every counter-aligned period and compares each count, and the done flag, against a period-by-period model of progress and guard state.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic {
        MOD_FALL = 1'b0,
        MOD_RISE = 1'b1
    } mod_edge_e;

    localparam int CFG_B_FROM_F4R4 = 0;
    localparam int CFG_A_FROM_F3R3 = 1;
    localparam int CFG_B_FROM_PER  = 2;
    localparam int CFG_A_COPY_B    = 3;
    localparam int CFG_GUARD_POL   = 6;
    localparam int CFG_GUARD_EN    = 7;
endpackage

// File: rtl/ssr_span_sel.sv
module ssr_span_sel
    import ssr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0]      period_i,
    input  logic [3:0][CW-1:0] rise_i,
    input  logic [3:0][CW-1:0] fall_i,
    input  logic [3:0]         sel_i,
    output logic [CW-1:0]      span_a_o,
    output logic [CW-1:0]      span_b_o
);
    function automatic logic [CW-1:0] diff_mod(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                               input logic [CW-1:0] p);
        return (a >= b) ? (a - b) : (a + p - b);
    endfunction

    function automatic logic [CW-1:0] diff_abs(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    always_comb begin
        span_a_o = diff_mod(fall_i[0], rise_i[0], period_i);
        span_b_o = diff_mod(fall_i[1], rise_i[1], period_i);
        if (sel_i[CFG_A_FROM_F3R3]) span_a_o = diff_abs(fall_i[2], rise_i[2]);
        if (sel_i[CFG_B_FROM_PER])  span_b_o = period_i - rise_i[1];
        if (sel_i[CFG_B_FROM_F4R4]) span_b_o = diff_abs(fall_i[3], rise_i[3]);
        if (sel_i[CFG_A_COPY_B])    span_a_o = span_b_o;
    end
endmodule

// File: rtl/ssr_ramp.sv
module ssr_ramp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [CW-1:0] step_i,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] span_a_i,
    input  logic [CW-1:0] span_b_i,
    output logic [CW-1:0] off_a_o,
    output logic [CW-1:0] off_b_o,
    output logic          done_o
);
    typedef struct packed {
        logic [CW-1:0] prog;
        logic          done;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic [CW:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.prog} + {1'b0, step_i};
        if (tick_i) begin
            if (en_i) begin
                st_d.prog = (sum > {1'b0, period_i}) ? period_i : sum[CW-1:0];
                st_d.done = (st_d.prog >= span_a_i) && (st_d.prog >= span_b_i);
            end else begin
                st_d.prog = '0;
                st_d.done = 1'b0;
            end
        end
        off_a_o = (span_a_i > st_q.prog) ? (span_a_i - st_q.prog) : '0;
        off_b_o = (span_b_i > st_q.prog) ? (span_b_i - st_q.prog) : '0;
        done_o  = st_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: progress moves only at a period end
    a_r6_prog_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.prog));
    // R7: done only rises after an enabled period end
    a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(tick_i && en_i));
    // R8: a disabled period end restores full spans
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !en_i) |=> (st_q.prog == '0) && !st_q.done);
endmodule

// File: rtl/ssr_edge_gen.sv
module ssr_edge_gen
    import ssr_pkg::*;
#(
    parameter int        CW   = 8,
    parameter mod_edge_e MODE = MOD_FALL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] rise_i,
    input  logic [CW-1:0] fall_i,
    input  logic [CW-1:0] off_i,
    input  logic          guard_on_i,
    input  logic          fall_after_i,
    output logic          pwm_o
);
    typedef struct packed {
        logic pwm;
    } edge_st_t;

    edge_st_t      st_d, st_q;
    logic [CW-1:0] base, pos, r_eff, f_eff;

    always_comb begin
        st_d  = st_q;
        base  = (MODE == MOD_FALL) ? fall_i : rise_i;
        pos   = (off_i > base) ? (base + period_i - off_i) : (base - off_i);
        r_eff = rise_i;
        f_eff = fall_i;
        if (MODE == MOD_FALL) f_eff = pos;
        else                  r_eff = pos;
        if (guard_on_i) begin
            if (fall_after_i && (f_eff < r_eff)) begin
                if (MODE == MOD_FALL) f_eff = r_eff;
                else                  r_eff = f_eff;
            end else if (!fall_after_i && (r_eff < f_eff)) begin
                if (MODE == MOD_FALL) f_eff = r_eff;
                else                  r_eff = f_eff;
            end
        end
        if (r_eff == f_eff)    st_d.pwm = 1'b0;
        else if (r_eff < f_eff) st_d.pwm = (cnt_i >= r_eff) && (cnt_i < f_eff);
        else                    st_d.pwm = (cnt_i >= r_eff) || (cnt_i < f_eff);
        pwm_o = st_q.pwm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: coinciding programmed edges with no offset give a low output
    a_r1_equal_edges_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_i == fall_i) && (off_i == '0)) |=> !st_q.pwm);
endmodule

// File: rtl/ssr_pwm_softstart.sv
module ssr_pwm_softstart
    import ssr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     period_i,
    input  logic [3:0][CW-1:0] rise_i,
    input  logic [3:0][CW-1:0] fall_i,
    input  logic              ss_en_i,
    input  logic [CW-1:0]     step_i,
    input  logic [7:0]        cfg_i,
    output logic [3:0]        pwm_o,
    output logic              ramp_done_o
);
    localparam int NOUT = 4;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          tick;
    logic [CW-1:0] span_a, span_b, off_a, off_b;
    logic          done;
    logic          cfg_unused;

    assign cfg_unused = ^cfg_i[5:4];

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.cnt >= (period_i - CW'(1)));
        st_d.cnt = tick ? '0 : (st_q.cnt + CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ssr_span_sel #(.CW(CW)) u_span (
        .period_i (period_i),
        .rise_i   (rise_i),
        .fall_i   (fall_i),
        .sel_i    (cfg_i[3:0]),
        .span_a_o (span_a),
        .span_b_o (span_b)
    );

    ssr_ramp #(.CW(CW)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ss_en_i),
        .tick_i   (tick),
        .step_i   (step_i),
        .period_i (period_i),
        .span_a_i (span_a),
        .span_b_i (span_b),
        .off_a_o  (off_a),
        .off_b_o  (off_b),
        .done_o   (done)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        localparam mod_edge_e M = (g < 2) ? MOD_FALL : MOD_RISE;
        logic [CW-1:0] off_sel;
        logic          fall_after;
        assign off_sel    = (g % 2 == 0) ? off_a : off_b;
        assign fall_after = (g < 2) ? 1'b1 : cfg_i[CFG_GUARD_POL];
        ssr_edge_gen #(.CW(CW), .MODE(M)) u_edge (
            .clk          (clk),
            .rst_n        (rst_n),
            .cnt_i        (st_q.cnt),
            .period_i     (period_i),
            .rise_i       (rise_i[g]),
            .fall_i       (fall_i[g]),
            .off_i        (off_sel),
            .guard_on_i   (cfg_i[CFG_GUARD_EN] && !done),
            .fall_after_i (fall_after),
            .pwm_o        (pwm_o[g])
        );
    end

    assign ramp_done_o = done;

    // R7: a done ramp has both offsets at zero
    a_r7_done_offsets_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done_o |-> ((off_a == '0) && (off_b == '0)));
    // R6: offsets never exceed the period for legal edge programming
    a_r6_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_i[0] < period_i) && (fall_i[0] < period_i) && (rise_i[1] < period_i) &&
         (fall_i[1] < period_i) && (rise_i[2] < period_i) && (fall_i[2] < period_i) &&
         (rise_i[3] < period_i) && (fall_i[3] < period_i)) |-> ((off_a <= period_i) && (off_b <= period_i)));
endmodule

// File: tb/tb_ssr_pwm_softstart.sv
module tb_ssr_pwm_softstart;
    localparam int CW         = 8;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 48;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CW-1:0]      period_i = CW'(P);
    logic [3:0][CW-1:0] rise_i = '0;
    logic [3:0][CW-1:0] fall_i = '0;
    logic               ss_en_i = 1'b0;
    logic [CW-1:0]      step_i = '0;
    logic [7:0]         cfg_i = '0;
    logic [3:0]         pwm_o;
    logic               ramp_done_o;

    ssr_pwm_softstart #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .rise_i(rise_i), .fall_i(fall_i),
        .ss_en_i(ss_en_i), .step_i(step_i), .cfg_i(cfg_i), .pwm_o(pwm_o), .ramp_done_o(ramp_done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    duty[4];
        bit    done;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_tests = 0;
    int   n_fail = 0;
    int   samp = 0;
    int   hi[4];
    bit   mon_on = 1'b0;

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: counts high cycles per counter-aligned period and pops the scoreboard
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            for (int i = 0; i < 4; i++) hi[i] += int'(pwm_o[i]);
            if (samp % P == P - 1) begin
                if (sbq.size() > 0) begin
                    exp_t e;
                    e = sbq.pop_front();
                    for (int i = 0; i < 4; i++)
                        check(e.tag, hi[i], e.duty[i], $sformatf("duty out%0d win%0d", i + 1, samp / P));
                    check("R7", int'(ramp_done_o), int'(e.done), $sformatf("done win%0d", samp / P));
                end
                for (int i = 0; i < 4; i++) hi[i] = 0;
            end
            samp++;
        end
    end

    function automatic int dmod(input int a, input int b);
        return (a >= b) ? a - b : a + P - b;
    endfunction

    function automatic int dabs(input int a, input int b);
        return (a >= b) ? a - b : b - a;
    endfunction

    function automatic int duty_of(input int r, input int f);
        if (r == f) return 0;
        if (r < f) return f - r;
        return P - r + f;
    endfunction

    task automatic run_case(input string tag, input int cfg, input int r[4], input int f[4],
                            input int step, input int nwin, input int drop_w);
        int sa, sb, p, off, rr, ff;
        bit dn, en;
        exp_t e;
        mon_on = 1'b0;
        rst_n  = 1'b0;
        cfg_i  = 8'(cfg);
        step_i = CW'(step);
        ss_en_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rise_i[i] = CW'(r[i]);
            fall_i[i] = CW'(f[i]);
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12", int'(pwm_o), 0, "pwm in reset");
        check("R12", int'(ramp_done_o), 0, "done in reset");
        // span model (R3, R4, R5)
        sa = dmod(f[0], r[0]);
        sb = dmod(f[1], r[1]);
        if (cfg[1]) sa = dabs(f[2], r[2]);
        if (cfg[2]) sb = P - r[1];
        if (cfg[0]) sb = dabs(f[3], r[3]);
        if (cfg[3]) sa = sb;
        p = 0;
        dn = 1'b0;
        for (int w = 0; w < nwin; w++) begin
            en = (w < drop_w);
            for (int i = 0; i < 4; i++) begin
                off = (i % 2 == 0) ? ((sa > p) ? sa - p : 0) : ((sb > p) ? sb - p : 0);
                rr = r[i];
                ff = f[i];
                if (i < 2) ff = (off > f[i]) ? f[i] + P - off : f[i] - off;
                else       rr = (off > r[i]) ? r[i] + P - off : r[i] - off;
                if (cfg[7] && !dn) begin
                    if (i < 2) begin
                        if (ff < rr) ff = rr;
                    end else if (cfg[6]) begin
                        if (ff < rr) rr = ff;
                    end else begin
                        if (rr < ff) rr = ff;
                    end
                end
                e.duty[i] = duty_of(rr, ff);
            end
            if (en) begin
                p = (p + step > P) ? P : p + step;
                dn = (p >= sa) && (p >= sb);
            end else begin
                p = 0;
                dn = 1'b0;
            end
            e.done = dn;
            e.tag  = tag;
            sbq.push_back(e);
        end
        samp = 0;
        for (int i = 0; i < 4; i++) hi[i] = 0;
        mon_on = 1'b1;
        #1 rst_n = 1'b1;
        if (drop_w < nwin) begin
            repeat (drop_w * P) @(negedge clk);
            #1 ss_en_i = 1'b0;
            repeat ((nwin - drop_w) * P) @(negedge clk);
        end else begin
            repeat (nwin * P) @(negedge clk);
        end
        #1;
        check(tag, sbq.size(), 0, "scoreboard drained");
        mon_on = 1'b0;
        sbq.delete();
    endtask

    initial begin
        // R2: reference full-bridge setup, period 48 ticks
        run_case("R2", 8'h00, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 5, 7, 99);
        // R3: default span wraps modulo the period
        run_case("R3", 8'h00, '{5, 24, 21, 45}, '{2, 44, 47, 23}, 10, 6, 99);
        // R5: span A follows span B
        run_case("R5", 8'h08, '{0, 24, 21, 45}, '{10, 44, 47, 23}, 5, 6, 99);
        // R4: span B from period minus rise2
        run_case("R4", 8'h04, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 6, 6, 99);
        // R4: span A from output 3, span B from output 4
        run_case("R4", 8'h03, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 6, 6, 99);
        // R4: bit 0 takes precedence over bit 2
        run_case("R4", 8'h05, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 6, 6, 99);
        // R9: guard blanks output 1 with wrapped falling edge
        run_case("R9", 8'h82, '{30, 24, 21, 45}, '{40, 44, 47, 23}, 8, 6, 99);
        // R11: same setup without guard keeps the wrapped pulse
        run_case("R11", 8'h02, '{30, 24, 21, 45}, '{40, 44, 47, 23}, 8, 6, 99);
        // R10: rising after falling for outputs 3 and 4
        run_case("R10", 8'h80, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 5, 6, 99);
        // R10: falling after rising for outputs 3 and 4
        run_case("R10", 8'hC0, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 5, 6, 99);
        // R6: step beyond span saturates in one period
        run_case("R6", 8'h00, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 60, 3, 99);
        // R6: zero step never completes
        run_case("R6", 8'h00, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 0, 3, 99);
        // R6: step not dividing the span
        run_case("R6", 8'h80, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 7, 5, 99);
        // R8: enable dropped after three periods
        run_case("R8", 8'h00, '{0, 24, 21, 45}, '{20, 44, 47, 23}, 5, 7, 3);
        // R1: coinciding programmed edges stay low
        run_case("R1", 8'h00, '{10, 24, 30, 45}, '{10, 44, 30, 23}, 5, 4, 99);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule